// File: doc/BRIEF.md
# Double-Buffered Parallel Converter Register Front End

This block is the digital front end of a single-channel voltage-output converter. A host writes a code word, together with a gain-select bit and a reference-buffer-select bit, over a parallel bus. The word goes into a holding (input) stage first. It reaches the active stage, which drives the converter, only when a separate load strobe says so. Several converters can then share one load line and change their outputs together.

All host pins are asynchronous to the block. They pass through two-flop synchronizers on a free-running clock. Strobe edges are found by comparing successive synchronized samples. The nanosecond timing limits become cycle counts through a clock-period parameter. A raw active-low clear empties both stages without waiting for a clock. A sticky flag reports strobe pulses or write spacing that are too short. A power-down pin raises a flag and leaves the stored words untouched.

Top module: `pardac_regs`

## Requirements
- R1: When the synchronized write strobe rises while chip select is low, the data bus and both mode bits are stored in the input stage. When chip select is high, a write strobe stores nothing.
- R2: A falling edge of the synchronized load strobe copies the input stage (code and mode bits) into the active stage.
- R3: If the load strobe is low at the moment a qualified write strobe rises, the active stage takes the newly written word at that same update.
- R4: If the load strobe stays high, a write leaves the active code and mode outputs at their previous values.
- R5: Driving clear low zeros the active outputs at once, with no clock edge needed, and also zeros the input stage, so a later load yields code 0.
- R6: After reset, the active code, gain, buffer, power-down and violation outputs are all 0.
- R7: The gain and buffer bits travel with the code through both stages. They appear on the outputs on the same update as the code.
- R8: While power-down is low, the power-down flag is 1 and the stored words are unchanged. Writes and loads still take effect. The flag returns to 0 when the pin returns high.
- R9: A write strobe that stays low for fewer than ceil(20 ns / clock period) cycles (2 at 10 ns) sets the violation flag.
- R10: A load or clear pulse that stays low for fewer than ceil(20 ns / clock period) cycles sets the violation flag.
- R11: Two accepted writes whose strobe rising edges are fewer than ceil(50 ns / clock period) cycles apart (5 at 10 ns) set the violation flag.
- R12: The violation flag stays set until the falling edge of the next clear or until reset. A violation detected in the same cycle as a clear edge wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock |
| rstN | input | 1 | Active-low reset, asynchronous assert |
| csN | input | 1 | Active-low chip select |
| wrN | input | 1 | Active-low write strobe |
| ldacN | input | 1 | Active-low load strobe |
| clrN | input | 1 | Active-low asynchronous clear of both stages |
| pdN | input | 1 | Active-low power-down request |
| dataIn | input | DATA_W | Parallel code word |
| gainIn | input | 1 | Gain select written with the code |
| bufIn | input | 1 | Reference-buffer select written with the code |
| activeCode | output | DATA_W | Code held in the active stage |
| gainOut | output | 1 | Gain bit of the active stage |
| bufOut | output | 1 | Buffer bit of the active stage |
| pdFlag | output | 1 | High while power-down is requested |
| timingViol | output | 1 | Sticky strobe timing violation flag |

## Verification
The update paths are each driven on their own:
- A write with load held high, followed later by a separate load pulse, tells the two-step update apart from the direct one.
- A write with load already low checks that the new word, and not the old input stage, reaches the output.
- A write with chip select high, followed by a load, shows that a deselected write stores nothing.

The remaining stimulus covers clear, power-down and timing:
- Clear and power-down are applied between writes, and each stage is read back through a later load.
- Pulses exactly one cycle short of each limit, and two writes spaced too closely, must raise the flag.
- The flag must then survive an ordinary write and drop only at a clear.

// File: rtl/pardac_pkg.sv
package pardac_pkg;

  // Pulses from the control path to the register path, one cycle each.
  typedef struct packed {
    logic capture;  // store bus into input stage
    logic loadNew;  // store bus straight into active stage
    logic copy;     // move input stage into active stage
  } strobe_t;

  // Nanoseconds rounded up to whole clock cycles.
  function automatic int cyclesFor(input int ns, input int periodNs);
    return (ns + periodNs - 1) / periodNs;
  endfunction

endpackage

// File: rtl/pardac_sync.sv
module pardac_sync #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] async,
  output logic [W-1:0] synced
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= RST_VAL;
      synced <= RST_VAL;
    end else begin
      stage1 <= async;
      synced <= stage1;
    end
  end
endmodule

// File: rtl/pardac_pulsechk.sv
module pardac_pulsechk #(
  parameter int MIN_CYC = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sigNow,
  input  logic sigPrev,
  output logic tooShort
);
  localparam int CW = $clog2(MIN_CYC + 1) + 1;
  localparam logic [CW-1:0] LIM = CW'(MIN_CYC);

  logic [CW-1:0] lowCnt;
  logic fallSeen, riseSeen;

  assign fallSeen = !sigNow && sigPrev;
  assign riseSeen = sigNow && !sigPrev;

  // Count low cycles from the falling edge, saturating at the limit.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowCnt <= LIM;
    else if (fallSeen) lowCnt <= CW'(1);
    else if (!sigNow && lowCnt < LIM) lowCnt <= lowCnt + CW'(1);
  end

  assign tooShort = riseSeen && (lowCnt < LIM);
endmodule

// File: rtl/pardac_ctrl.sv
module pardac_ctrl
  import pardac_pkg::*;
#(
  parameter int WR_CYC  = 2,
  parameter int LD_CYC  = 2,
  parameter int CLR_CYC = 2,
  parameter int GAP_CYC = 5
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csS,
  input  logic    wrS,
  input  logic    ldS,
  input  logic    clrS,
  output strobe_t stb,
  output logic    violFlag
);
  localparam int NCHK = 3;  // 0: write, 1: load, 2: clear
  localparam int GW = $clog2(GAP_CYC + 1) + 1;
  localparam logic [GW-1:0] GAP_LIM = GW'(GAP_CYC);

  logic [NCHK-1:0] sigNow, sigPrev, shortPulse;
  logic wrRise, ldFall, clrFall, gapViol, gapValid;
  logic [GW-1:0] gapCnt;

  assign sigNow = {clrS, ldS, wrS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sigPrev <= '1;
    else       sigPrev <= sigNow;
  end

  generate
    for (genvar i = 0; i < NCHK; i++) begin : g_width
      pardac_pulsechk #(
        .MIN_CYC((i == 0) ? WR_CYC : (i == 1) ? LD_CYC : CLR_CYC)
      ) u_chk (
        .clk     (clk),
        .rstN    (rstN),
        .sigNow  (sigNow[i]),
        .sigPrev (sigPrev[i]),
        .tooShort(shortPulse[i])
      );
    end
  endgenerate

  assign wrRise  = wrS && !sigPrev[0];
  assign ldFall  = !ldS && sigPrev[1];
  assign clrFall = !clrS && sigPrev[2];

  assign stb.capture = wrRise && !csS;
  assign stb.loadNew = stb.capture && !ldS;
  assign stb.copy    = ldFall;

  // Spacing between accepted writes, rising edge to rising edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt   <= GAP_LIM;
      gapValid <= 1'b0;
    end else if (stb.capture) begin
      gapCnt   <= GW'(1);
      gapValid <= 1'b1;
    end else if (gapCnt < GAP_LIM) begin
      gapCnt <= gapCnt + GW'(1);
    end
  end

  assign gapViol = stb.capture && gapValid && (gapCnt < GAP_LIM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     violFlag <= 1'b0;
    else if (|shortPulse || gapViol) violFlag <= 1'b1;
    else if (clrFall)              violFlag <= 1'b0;
  end

  p_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    violFlag && !clrFall |=> violFlag);
  p_width_r9: assert property (@(posedge clk) disable iff (!rstN)
    shortPulse[0] |=> violFlag);
  p_gap_r11: assert property (@(posedge clk) disable iff (!rstN)
    gapViol |=> violFlag);
endmodule

// File: rtl/pardac_dpath.sv
module pardac_dpath
  import pardac_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clrN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] dataS,
  input  logic              gainS,
  input  logic              bufS,
  output logic [DATA_W-1:0] activeCode,
  output logic              gainQ,
  output logic              bufQ
);
  typedef struct packed {
    logic [DATA_W-1:0] code;
    logic              gain;
    logic              buffer;
  } word_t;

  word_t busWord, inReg, actReg;
  logic clrAll;

  assign clrAll  = rstN & clrN;
  assign busWord = '{code: dataS, gain: gainS, buffer: bufS};

  always_ff @(posedge clk or negedge clrAll) begin
    if (!clrAll)          inReg <= '0;
    else if (stb.capture) inReg <= busWord;
  end

  always_ff @(posedge clk or negedge clrAll) begin
    if (!clrAll)          actReg <= '0;
    else if (stb.loadNew) actReg <= busWord;
    else if (stb.copy)    actReg <= inReg;
  end

  assign activeCode = actReg.code;
  assign gainQ      = actReg.gain;
  assign bufQ       = actReg.buffer;

  p_copy_r2: assert property (@(posedge clk) disable iff (!clrAll)
    stb.copy && !stb.loadNew |=> actReg == $past(inReg));
  p_sync_r3: assert property (@(posedge clk) disable iff (!clrAll)
    stb.loadNew |=> activeCode == $past(dataS));
  p_hold_r4: assert property (@(posedge clk) disable iff (!clrAll)
    !(stb.loadNew || stb.copy) |=> $stable(actReg));
  p_clear_r5: assert property (@(posedge clk)
    !clrAll |-> (activeCode == '0 && !gainQ && !bufQ));
endmodule

// File: rtl/pardac_regs.sv
module pardac_regs
  import pardac_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int CLK_NS     = 10,
  parameter int WR_MIN_NS  = 20,
  parameter int LD_MIN_NS  = 20,
  parameter int CLR_MIN_NS = 20,
  parameter int GAP_MIN_NS = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wrN,
  input  logic              ldacN,
  input  logic              clrN,
  input  logic              pdN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              gainIn,
  input  logic              bufIn,
  output logic [DATA_W-1:0] activeCode,
  output logic              gainOut,
  output logic              bufOut,
  output logic              pdFlag,
  output logic              timingViol
);
  localparam int WR_CYC  = cyclesFor(WR_MIN_NS, CLK_NS);
  localparam int LD_CYC  = cyclesFor(LD_MIN_NS, CLK_NS);
  localparam int CLR_CYC = cyclesFor(CLR_MIN_NS, CLK_NS);
  localparam int GAP_CYC = cyclesFor(GAP_MIN_NS, CLK_NS);
  localparam int NCTL = 5;
  localparam int SW = NCTL + 2 + DATA_W;

  logic [SW-1:0] pinsRaw, pinsS;
  logic csS, wrS, ldS, clrS, pdS, gainS, bufS;
  logic [DATA_W-1:0] dataS;
  strobe_t stb;

  assign pinsRaw = {pdN, clrN, ldacN, wrN, csN, gainIn, bufIn, dataIn};

  pardac_sync #(
    .W      (SW),
    .RST_VAL({{NCTL{1'b1}}, {(SW - NCTL){1'b0}}})
  ) u_sync (
    .clk   (clk),
    .rstN  (rstN),
    .async (pinsRaw),
    .synced(pinsS)
  );

  assign {pdS, clrS, ldS, wrS, csS, gainS, bufS, dataS} = pinsS;

  pardac_ctrl #(
    .WR_CYC (WR_CYC),
    .LD_CYC (LD_CYC),
    .CLR_CYC(CLR_CYC),
    .GAP_CYC(GAP_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .csS     (csS),
    .wrS     (wrS),
    .ldS     (ldS),
    .clrS    (clrS),
    .stb     (stb),
    .violFlag(timingViol)
  );

  pardac_dpath #(
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .clrN      (clrN),
    .stb       (stb),
    .dataS     (dataS),
    .gainS     (gainS),
    .bufS      (bufS),
    .activeCode(activeCode),
    .gainQ     (gainOut),
    .bufQ      (bufOut)
  );

  assign pdFlag = !pdS;
endmodule

// File: tb/pardac_regs_bench.sv
module pardac_regs_bench;
  localparam int DW = 12;

  logic clk = 1'b0;
  logic rstN, csN, wrN, ldacN, clrN, pdN, gainIn, bufIn;
  logic [DW-1:0] dataIn, activeCode;
  logic gainOut, bufOut, pdFlag, timingViol;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  // Reference model
  logic [DW-1:0] expInCode, expActCode;
  logic expInGain, expInBuf, expActGain, expActBuf, expViol;

  always #5 clk = ~clk;

  pardac_regs #(.DATA_W(DW)) u_pardac_regs (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .ldacN(ldacN),
    .clrN(clrN), .pdN(pdN), .dataIn(dataIn), .gainIn(gainIn), .bufIn(bufIn),
    .activeCode(activeCode), .gainOut(gainOut), .bufOut(bufOut),
    .pdFlag(pdFlag), .timingViol(timingViol)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic checkOutputs(input string req);
    check({req, " code"}, int'(activeCode), int'(expActCode));
    check({req, " gain"}, int'(gainOut), int'(expActGain));
    check({req, " buf"}, int'(bufOut), int'(expActBuf));
    check({req, " viol"}, int'(timingViol), int'(expViol));
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One write cycle. ldLow: hold load low across the write (direct update).
  task automatic doWrite(input logic [DW-1:0] d, input logic g, input logic b,
                         input logic sel, input logic ldLow, input int lowCyc);
    @(negedge clk);
    csN = !sel; dataIn = d; gainIn = g; bufIn = b;
    if (ldLow) ldacN = 1'b0;
    waitCyc(1);
    wrN = 1'b0;
    waitCyc(lowCyc);
    wrN = 1'b1;
    waitCyc(3);
    csN = 1'b1;
    if (ldLow) ldacN = 1'b1;
    waitCyc(4);
    if (ldLow) begin  // load fall first copies the old input stage
      expActCode = expInCode; expActGain = expInGain; expActBuf = expInBuf;
    end
    if (sel) begin
      expInCode = d; expInGain = g; expInBuf = b;
      if (ldLow) begin
        expActCode = d; expActGain = g; expActBuf = b;
      end
    end
    if (lowCyc < 2) expViol = 1'b1;
  endtask

  task automatic pulseLoad(input int lowCyc);
    @(negedge clk);
    ldacN = 1'b0;
    waitCyc(lowCyc);
    ldacN = 1'b1;
    waitCyc(5);
    expActCode = expInCode; expActGain = expInGain; expActBuf = expInBuf;
    if (lowCyc < 2) expViol = 1'b1;
  endtask

  task automatic pulseClear(input int lowCyc);
    @(negedge clk);
    clrN = 1'b0;
    #1;
    check("R5 code zero during clear", int'(activeCode), 0);
    waitCyc(lowCyc);
    clrN = 1'b1;
    waitCyc(5);
    expInCode = '0; expInGain = 1'b0; expInBuf = 1'b0;
    expActCode = '0; expActGain = 1'b0; expActBuf = 1'b0;
    expViol = (lowCyc < 2);
  endtask

  task automatic testReset();
    checkOutputs("R6 reset");
    check("R6 pd flag reset", int'(pdFlag), 0);
  endtask

  task automatic testTwoStep();
    doWrite(12'hA5C, 1'b1, 1'b0, 1'b1, 1'b0, 4);
    checkOutputs("R4 no load keeps old code");
    pulseLoad(3);
    checkOutputs("R2 load copies word, R7 mode bits");
    check("R2 code value", int'(activeCode), 'hA5C);
  endtask

  task automatic testDeselected();
    doWrite(12'h123, 1'b0, 1'b1, 1'b0, 1'b0, 4);
    pulseLoad(3);
    checkOutputs("R1 deselected write ignored");
    check("R1 code kept", int'(activeCode), 'hA5C);
  endtask

  task automatic testDirect();
    doWrite(12'h3F0, 1'b0, 1'b1, 1'b1, 1'b1, 4);
    checkOutputs("R3 direct update, R7 mode bits");
    check("R3 code value", int'(activeCode), 'h3F0);
  endtask

  task automatic testClear();
    doWrite(12'h7E1, 1'b1, 1'b1, 1'b1, 1'b0, 4);
    pulseClear(4);
    checkOutputs("R5 after clear");
    pulseLoad(3);
    checkOutputs("R5 input stage cleared");
  endtask

  task automatic testPowerDown();
    doWrite(12'h456, 1'b1, 1'b0, 1'b1, 1'b0, 4);
    pulseLoad(3);
    @(negedge clk);
    pdN = 1'b0;
    waitCyc(4);
    check("R8 pd flag set", int'(pdFlag), 1);
    checkOutputs("R8 words held in power-down");
    doWrite(12'h9AB, 1'b0, 1'b1, 1'b1, 1'b0, 4);
    pulseLoad(3);
    checkOutputs("R8 write and load accepted in power-down");
    pdN = 1'b1;
    waitCyc(4);
    check("R8 pd flag released", int'(pdFlag), 0);
    checkOutputs("R8 words after power-down");
  endtask

  task automatic testShortWrite();
    doWrite(12'h0F3, 1'b0, 1'b0, 1'b1, 1'b0, 1);
    check("R9 short write flags", int'(timingViol), 1);
    doWrite(12'h0F4, 1'b0, 1'b0, 1'b1, 1'b0, 4);
    check("R12 flag sticky after clean write", int'(timingViol), 1);
    pulseLoad(3);
    checkOutputs("R12 sticky with load");
    pulseClear(4);
    check("R12 flag cleared by clear", int'(timingViol), 0);
  endtask

  task automatic testShortLoadClear();
    doWrite(12'h5A5, 1'b1, 1'b0, 1'b1, 1'b0, 4);
    pulseLoad(1);
    checkOutputs("R10 short load flags and copies");
    pulseClear(4);
    check("R10 flag cleared", int'(timingViol), 0);
    pulseClear(1);
    checkOutputs("R10 short clear flags");
    pulseClear(4);
  endtask

  task automatic testGap();
    waitCyc(8);
    @(negedge clk);
    csN = 1'b0; dataIn = 12'h111; gainIn = 1'b0; bufIn = 1'b0;
    waitCyc(1);
    wrN = 1'b0; waitCyc(2);
    wrN = 1'b1; waitCyc(1);
    dataIn = 12'h222;
    wrN = 1'b0; waitCyc(2);
    wrN = 1'b1; waitCyc(3);
    csN = 1'b1;
    waitCyc(4);
    expInCode = 12'h222; expInGain = 1'b0; expInBuf = 1'b0;
    expViol = 1'b1;
    check("R11 close writes flag", int'(timingViol), 1);
    pulseLoad(3);
    checkOutputs("R11 second word stored");
  endtask

  initial begin
    rstN = 1'b1; csN = 1'b1; wrN = 1'b1; ldacN = 1'b1; clrN = 1'b1; pdN = 1'b1;
    dataIn = '0; gainIn = 1'b0; bufIn = 1'b0;
    expInCode = '0; expActCode = '0; expInGain = 1'b0; expInBuf = 1'b0;
    expActGain = 1'b0; expActBuf = 1'b0; expViol = 1'b0;
    #1 rstN = 1'b0;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(3);
    testReset();
    testTwoStep();
    testDeselected();
    testDirect();
    testClear();
    testPowerDown();
    testShortWrite();
    testShortLoadClear();
    testGap();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule